// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the register-transfer datapath of a small 32-bit load/store processor. It executes add, subtract, and, or, set-less-than, word load, word store, branch-if-equal and jump, and it spends several clock cycles on each instruction. Each instruction is split into fetch, register read, ALU work, memory access and write-back steps, and it uses only the steps it needs. State that one step produces and a later step consumes is held in internal registers: the program counter, the instruction register, the memory data register, the two operand latches and the ALU result latch.

A single word-addressed memory inside the block holds both code and data. A single ALU computes arithmetic results, data addresses, the incremented PC and branch targets, each in a different cycle. The block contains no sequencing logic. An external control unit supplies every multiplexer select and every write enable, one set per cycle. The block returns to that controller the opcode, the function field and the ALU zero flag. A fill port writes words into the memory before or between instructions. The PC and the live ALU value are also brought out as ports.

Top module: `mcdp_top`

## Requirements
- R1: The memory word index is address bits [7:2]. With `iorD`=0 that address is the PC. With `iorD`=1 it is the ALU result latch, which a load reads and a store writes. A store writes the B operand latch at the clock edge when `memWrite`=1. The memory data register captures the word read in every cycle.
- R2: The instruction register loads the memory word only at an edge where `irWrite`=1, and it keeps its value at every other edge. `opcode` shows instruction bits [31:26] and `funct` shows bits [5:0].
- R3: The first ALU operand is the PC when `aluSrcA`=0 and the A latch when it is 1. The second operand `aluSrcB` selects: 0 the B latch, 1 the constant 4, 2 the sign-extended immediate in bits [15:0], 3 that immediate shifted left by two. In the fetch cycle, `aluValue` equals PC+4.
- R4: `aluCtl` codes select the operation: 000 and, 001 or, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). `zero` is 1 exactly when `aluValue` is 0.
- R5: The register file read ports are addressed by instruction bits [25:21] and [20:16]. They are captured into the A and B latches at every edge, and the ALU result is captured into the ALU result latch at every edge.
- R6: The PC loads at an edge where `pcWrite`=1, or where `pcWriteCond`=1 and `zero`=1. Otherwise it holds its value. A branch-if-equal is therefore taken only when its two registers are equal.
- R7: `pcSource` selects the next PC: 0 the live ALU result, 1 the ALU result latch (branch target), 2 the jump address. The jump address is PC bits [31:28], then instruction bits [25:0], then two zero bits.
- R8: A register write at `regWrite`=1 goes to bits [15:11] with the ALU result latch as data when `regDst`=1 and `memToReg`=0. It goes to bits [20:16] with the memory data register as data when `regDst`=0 and `memToReg`=1.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: While `rstN` is low, the PC, the instruction register and the internal latches are cleared. As a result `pcValue`, `opcode` and `funct` read 0.
- R11: With `initWe`=1, `initData` is written to memory word `initAddr` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | PC load when the ALU result is zero |
| iorD | input | 1 | Memory address select: PC or ALU result latch |
| memWrite | input | 1 | Store the B latch into memory |
| irWrite | input | 1 | Load the instruction register |
| regDst | input | 1 | Destination field select for register write |
| memToReg | input | 1 | Register write data select |
| regWrite | input | 1 | Register file write enable |
| aluSrcA | input | 1 | First ALU operand select |
| aluSrcB | input | 2 | Second ALU operand select |
| pcSource | input | 2 | Next-PC select |
| aluCtl | input | 3 | ALU operation code |
| initWe | input | 1 | Memory fill write enable |
| initAddr | input | 6 | Memory fill word index |
| initData | input | 32 | Memory fill data |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| zero | output | 1 | ALU result equals zero |
| pcValue | output | 32 | Current PC |
| aluValue | output | 32 | Live ALU result |

## Verification
`aluValue` and `zero` are combinational. They are valid in the same cycle that the strobes are applied, and they use operands latched at the previous edge. The bench therefore drives each cycle's strobes at the falling edge and reads these outputs two time units later, before the next rising edge. `opcode` and `funct` change one edge after the fetch cycle, so the bench reads them in the decode cycle and again in every later cycle of the instruction. The effect of the PC update from the previous instruction shows in the next fetch cycle, and the bench checks it there. A register write shows up when a later instruction's execute cycle reads that register back through the ALU.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;
  localparam int XLEN      = 32;
  localparam int NREGS     = 32;
  localparam int REG_AW    = $clog2(NREGS);
  localparam int MEM_WORDS = 64;
  localparam int MEM_IDX_W = $clog2(MEM_WORDS);

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluOp_e;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iorD;
    logic       memWrite;
    logic       irWrite;
    logic       regDst;
    logic       memToReg;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] pcSource;
    aluOp_e     aluCtl;
  } strobes_t;
endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluOp_e         op,
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  output logic [W-1:0]   result,
  output logic           isZero
);
  always_comb begin
    unique case (op)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile
  import mcdp_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int N  = NREGS,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/mcdp_memory.sv
module mcdp_memory
  import mcdp_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int WORDS = MEM_WORDS,
  parameter int IW    = MEM_IDX_W
) (
  input  logic          clk,
  input  logic [IW-1:0] idx,
  input  logic          wrEn,
  input  logic [W-1:0]  wrData,
  input  logic          fillEn,
  input  logic [IW-1:0] fillIdx,
  input  logic [W-1:0]  fillData,
  output logic [W-1:0]  rdData
);
  logic [W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (fillEn)    store[fillIdx] <= fillData;
    else if (wrEn) store[idx]     <= wrData;
  end

  assign rdData = store[idx];
endmodule

// File: rtl/mcdp_datapath.sv
module mcdp_datapath
  import mcdp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             ctl,
  input  logic                 fillEn,
  input  logic [MEM_IDX_W-1:0] fillIdx,
  input  logic [XLEN-1:0]      fillData,
  output logic [5:0]           opcode,
  output logic [5:0]           funct,
  output logic                 zero,
  output logic [XLEN-1:0]      pcValue,
  output logic [XLEN-1:0]      aluValue
);
  logic [XLEN-1:0] pc, ir, mdr, aReg, bReg, aluOut;
  logic [XLEN-1:0] memRd, rdA, rdB, opA, opB, aluRes, nextPc;
  logic [XLEN-1:0] immExt, wrData;
  logic [MEM_IDX_W-1:0] memIdx;
  logic [REG_AW-1:0] wrAddr;
  logic pcLoad;

  assign memIdx = ctl.iorD ? aluOut[MEM_IDX_W+1:2] : pc[MEM_IDX_W+1:2];

  mcdp_memory u_mem (
    .clk(clk), .idx(memIdx), .wrEn(ctl.memWrite), .wrData(bReg),
    .fillEn(fillEn), .fillIdx(fillIdx), .fillData(fillData), .rdData(memRd)
  );

  assign wrAddr = ctl.regDst ? ir[15:11] : ir[20:16];
  assign wrData = ctl.memToReg ? mdr : aluOut;

  mcdp_regfile u_rf (
    .clk(clk), .rdAddrA(ir[25:21]), .rdAddrB(ir[20:16]),
    .rdDataA(rdA), .rdDataB(rdB),
    .wrEn(ctl.regWrite), .wrAddr(wrAddr), .wrData(wrData)
  );

  assign immExt = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign opA    = ctl.aluSrcA ? aReg : pc;

  always_comb begin
    unique case (ctl.aluSrcB)
      2'b00:   opB = bReg;
      2'b01:   opB = XLEN'(4);
      2'b10:   opB = immExt;
      default: opB = {immExt[XLEN-3:0], 2'b00};
    endcase
  end

  mcdp_alu u_alu (
    .op(ctl.aluCtl), .opA(opA), .opB(opB), .result(aluRes), .isZero(zero)
  );

  always_comb begin
    unique case (ctl.pcSource)
      2'b01:   nextPc = aluOut;
      2'b10:   nextPc = {pc[XLEN-1:28], ir[25:0], 2'b00};
      default: nextPc = aluRes;
    endcase
  end

  assign pcLoad = ctl.pcWrite || (ctl.pcWriteCond && zero);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      ir     <= '0;
      mdr    <= '0;
      aReg   <= '0;
      bReg   <= '0;
      aluOut <= '0;
    end else begin
      if (pcLoad)      pc <= nextPc;
      if (ctl.irWrite) ir <= memRd;
      mdr    <= memRd;
      aReg   <= rdA;
      bReg   <= rdB;
      aluOut <= aluRes;
    end
  end

  assign opcode   = ir[31:26];
  assign funct    = ir[5:0];
  assign pcValue  = pc;
  assign aluValue = aluRes;

  a_r2_ir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.irWrite |=> $stable(ir));

  a_r3_fetch_pc4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.aluSrcA && ctl.aluSrcB == 2'b01 && ctl.aluCtl == ALU_ADD)
      |-> aluValue == pc + XLEN'(4));

  a_r4_sub_equal: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.aluCtl == ALU_SUB && opA == opB) |-> zero);

  a_r6_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.pcWrite || (ctl.pcWriteCond && zero)) |=> $stable(pcValue));

  a_r6_branch_taken: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pcWriteCond && !ctl.pcWrite && zero && ctl.pcSource == 2'b01)
      |=> pcValue == $past(aluOut));

  a_r9_zero_read: assert property (@(posedge clk) disable iff (!rstN)
    (ir[25:21] == '0) |-> rdA == '0);
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
  import mcdp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pcWrite,
  input  logic                 pcWriteCond,
  input  logic                 iorD,
  input  logic                 memWrite,
  input  logic                 irWrite,
  input  logic                 regDst,
  input  logic                 memToReg,
  input  logic                 regWrite,
  input  logic                 aluSrcA,
  input  logic [1:0]           aluSrcB,
  input  logic [1:0]           pcSource,
  input  logic [2:0]           aluCtl,
  input  logic                 initWe,
  input  logic [MEM_IDX_W-1:0] initAddr,
  input  logic [XLEN-1:0]      initData,
  output logic [5:0]           opcode,
  output logic [5:0]           funct,
  output logic                 zero,
  output logic [XLEN-1:0]      pcValue,
  output logic [XLEN-1:0]      aluValue
);
  strobes_t ctl;

  always_comb begin
    ctl.pcWrite     = pcWrite;
    ctl.pcWriteCond = pcWriteCond;
    ctl.iorD        = iorD;
    ctl.memWrite    = memWrite;
    ctl.irWrite     = irWrite;
    ctl.regDst      = regDst;
    ctl.memToReg    = memToReg;
    ctl.regWrite    = regWrite;
    ctl.aluSrcA     = aluSrcA;
    ctl.aluSrcB     = aluSrcB;
    ctl.pcSource    = pcSource;
    ctl.aluCtl      = aluOp_e'(aluCtl);
  end

  mcdp_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .fillEn(initWe), .fillIdx(initAddr), .fillData(initData),
    .opcode(opcode), .funct(funct), .zero(zero),
    .pcValue(pcValue), .aluValue(aluValue)
  );
endmodule

// File: tb/tb_mcdp_top.sv
module tb_mcdp_top;
  import mcdp_pkg::*;
  localparam int PERIOD = 10;
  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2b,
                         OP_BEQ = 6'h04, OP_J = 6'h02;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24,
                         F_OR = 6'h25, F_SLT = 6'h2a;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  strobes_t ctl = '0;
  logic initWe = 1'b0;
  logic [MEM_IDX_W-1:0] initAddr = '0;
  logic [31:0] initData = '0;
  logic [5:0] opcode, funct;
  logic zero;
  logic [31:0] pcValue, aluValue;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] regM [32];
  logic [31:0] memM [MEM_WORDS];
  logic [31:0] pcM;

  always #(PERIOD/2) clk = ~clk;

  mcdp_top dut (
    .clk(clk), .rstN(rstN),
    .pcWrite(ctl.pcWrite), .pcWriteCond(ctl.pcWriteCond), .iorD(ctl.iorD),
    .memWrite(ctl.memWrite), .irWrite(ctl.irWrite), .regDst(ctl.regDst),
    .memToReg(ctl.memToReg), .regWrite(ctl.regWrite), .aluSrcA(ctl.aluSrcA),
    .aluSrcB(ctl.aluSrcB), .pcSource(ctl.pcSource), .aluCtl(ctl.aluCtl),
    .initWe(initWe), .initAddr(initAddr), .initData(initData),
    .opcode(opcode), .funct(funct), .zero(zero),
    .pcValue(pcValue), .aluValue(aluValue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input strobes_t s);
    @(negedge clk);
    ctl = s;
    initWe = 1'b0;
    #2;
  endtask

  task automatic fill(input int idx, input logic [31:0] d);
    @(negedge clk);
    ctl = '0;
    initWe = 1'b1;
    initAddr = MEM_IDX_W'(idx);
    initData = d;
    memM[idx] = d;
  endtask

  function automatic logic [31:0] rIns(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {OP_R, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iIns(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic aluOp_e ctlFor(input logic [5:0] fn);
    case (fn)
      F_ADD:   return ALU_ADD;
      F_SUB:   return ALU_SUB;
      F_AND:   return ALU_AND;
      F_OR:    return ALU_OR;
      default: return ALU_SLT;
    endcase
  endfunction

  function automatic logic [31:0] refAlu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      F_ADD:   return a + b;
      F_SUB:   return a - b;
      F_AND:   return a & b;
      F_OR:    return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic execIns(input logic [31:0] ins, input string tag);
    strobes_t s;
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    int rs = int'(ins[25:21]);
    int rt = int'(ins[20:16]);
    int rd = int'(ins[15:11]);
    logic [31:0] sx = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] tgt, res, addr;
    // fetch
    s = '0; s.irWrite = 1; s.aluSrcB = 2'b01; s.aluCtl = ALU_ADD; s.pcWrite = 1;
    drive(s);
    chk("R6 pc at fetch", pcValue, pcM);
    chk("R3 fetch pc+4", aluValue, pcM + 32'd4);
    pcM = pcM + 32'd4;
    tgt = pcM + {sx[29:0], 2'b00};
    // decode: branch target
    s = '0; s.aluSrcB = 2'b11; s.aluCtl = ALU_ADD;
    drive(s);
    chk("R2 opcode", 32'(opcode), 32'(op));
    chk("R2 funct", 32'(funct), 32'(fn));
    chk("R3 shifted imm target", aluValue, tgt);
    case (op)
      OP_R: begin
        res = refAlu(fn, regM[rs], regM[rt]);
        s = '0; s.aluSrcA = 1; s.aluCtl = ctlFor(fn);
        drive(s);
        chk(tag, aluValue, res);
        chk("R4 zero flag", 32'(zero), 32'(res == 32'd0));
        s = '0; s.regDst = 1; s.regWrite = 1;
        drive(s);
        chk("R2 ir hold", 32'(funct), 32'(fn));
        if (rd != 0) regM[rd] = res;
      end
      OP_LW, OP_SW: begin
        addr = regM[rs] + sx;
        s = '0; s.aluSrcA = 1; s.aluSrcB = 2'b10; s.aluCtl = ALU_ADD;
        drive(s);
        chk("R3 sign-extended address", aluValue, addr);
        s = '0; s.iorD = 1; s.memWrite = (op == OP_SW);
        drive(s);
        chk("R2 ir hold", 32'(opcode), 32'(op));
        if (op == OP_SW) begin
          memM[addr[MEM_IDX_W+1:2]] = regM[rt];
        end else begin
          s = '0; s.memToReg = 1; s.regWrite = 1;
          drive(s);
          if (rt != 0) regM[rt] = memM[addr[MEM_IDX_W+1:2]];
        end
      end
      OP_BEQ: begin
        s = '0; s.aluSrcA = 1; s.aluCtl = ALU_SUB; s.pcWriteCond = 1; s.pcSource = 2'b01;
        drive(s);
        chk(tag, 32'(zero), 32'(regM[rs] == regM[rt]));
        if (regM[rs] == regM[rt]) pcM = tgt;
      end
      default: begin
        s = '0; s.pcWrite = 1; s.pcSource = 2'b10;
        drive(s);
        chk("R2 ir hold", 32'(opcode), 32'(op));
        pcM = {pcM[31:28], ins[25:0], 2'b00};
      end
    endcase
  endtask

  task automatic issue(input logic [31:0] ins, input string tag);
    if (int'(pcM[MEM_IDX_W+1:2]) >= 40) begin
      fill(int'(pcM[MEM_IDX_W+1:2]), {OP_J, 26'd0});
      execIns({OP_J, 26'd0}, "R7 jump");
    end
    fill(int'(pcM[MEM_IDX_W+1:2]), ins);
    execIns(ins, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [8];
    logic [5:0] fns [5];
    vals[0] = 32'd0;        vals[1] = 32'd1;        vals[2] = 32'd5;
    vals[3] = 32'hfffffffd; vals[4] = 32'h7fffffff; vals[5] = 32'h80000000;
    vals[6] = 32'hffffffff; vals[7] = 32'd260;
    fns[0] = F_ADD; fns[1] = F_SUB; fns[2] = F_AND; fns[3] = F_OR; fns[4] = F_SLT;
    regM[0] = 32'd0;
    pcM = 32'd0;

    repeat (3) @(negedge clk);
    #2;
    chk("R10 reset pc", pcValue, 32'd0);
    chk("R10 reset opcode", 32'(opcode), 32'd0);
    chk("R10 reset funct", 32'(funct), 32'd0);
    chk("R10 reset alu", aluValue, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 8; i++) fill(48 + i, vals[i]);
    for (int i = 0; i < 8; i++) issue(iIns(OP_LW, 0, i + 1, 192 + 4 * i), "R11 fill/R1 load");
    for (int i = 1; i <= 8; i++) issue(rIns(F_OR, 20, i, 0), "R8 load write-back");

    for (int f = 0; f < 5; f++)
      for (int a = 1; a <= 8; a++)
        for (int b = 1; b <= 8; b++) begin
          issue(rIns(fns[f], 9, a, b), "R4 alu op");
          issue(rIns(F_OR, 10, 9, 0), "R8 r-type write-back/R5");
        end

    issue(rIns(F_ADD, 0, 2, 3), "R9 write to r0");
    issue(rIns(F_OR, 11, 0, 0), "R9 r0 reads zero");

    issue(iIns(OP_SW, 0, 4, 224), "R1 store");
    issue(iIns(OP_LW, 0, 12, 224), "R1 load back");
    issue(rIns(F_OR, 13, 12, 0), "R1 stored word");
    issue(iIns(OP_LW, 8, 14, -68), "R3 negative offset");
    issue(rIns(F_OR, 15, 14, 0), "R3 negative offset data");

    issue(iIns(OP_BEQ, 1, 1, 2), "R6 taken branch");
    issue(iIns(OP_BEQ, 2, 3, 2), "R6 untaken branch");
    issue({OP_J, 26'd5}, "R7 jump");
    issue(rIns(F_OR, 16, 2, 0), "R7 after jump");
    drive('0);
    chk("R6 final pc", pcValue, pcM);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule